// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms the memory address for a 16-bit processor that uses segmented addressing. Each request names an addressing mode and supplies the current contents of the four segment registers, the general base register, the stack-frame base pointer, the source and destination index registers, the instruction pointer and a displacement. The block sums the effective address from the terms that the mode calls for and picks a segment. It then appends a zero nibble to the segment value and adds the effective address, which gives a 20-bit physical address.

The block has one register stage. A request presented with `reqValid` high is captured at a rising clock edge, and its result appears on the outputs after that edge, marked by `outValid`. The default segment follows from the mode. The stack-frame base selects the stack segment, string destinations use the extra segment, relative references use the code segment, and everything else uses the data segment. A segment-override input can replace this default, except for a string destination.

Top module: `seg_addr_gen`

## Requirements
- R1: `outPhys` equals (segment value × 16 + `outEa`) modulo 2^20, where the segment value is the register selected by `outSeg`. The low four bits of `outPhys` always equal the low four bits of `outEa`.
- R2: Register-indirect mode (`mode` = 3'b001) uses the register chosen by `indSel` as the effective address: 00 general base, 01 stack-frame base, 10 source index, 11 destination index. The default segment is stack for 01 and data for the other three values.
- R3: Based mode (`mode` = 3'b010) adds the displacement to the base chosen by `baseSel` (0 general base, 1 stack-frame base). The default segment is data for 0 and stack for 1.
- R4: In based, indexed and based-indexed modes, `dispWide` = 1 adds all 16 bits of `disp` as an unsigned value. `dispWide` = 0 sign-extends `disp[7:0]` and ignores `disp[15:8]`. Every effective-address sum wraps modulo 2^16.
- R5: Indexed mode (`mode` = 3'b011) adds the displacement to the index chosen by `idxSel` (0 source, 1 destination). The default segment is data.
- R6: Based-indexed mode (`mode` = 3'b100) forms base (`baseSel`) + index (`idxSel`) + displacement. The default segment is data for the general base and stack for the stack-frame base.
- R7: String-source mode (`mode` = 3'b101) uses the source index with the data segment by default. String-destination mode (`mode` = 3'b110) uses the destination index with the extra segment, and `ovrValid` has no effect on it.
- R8: Direct mode (`mode` = 3'b000) uses all 16 bits of `disp` as the effective address, with the data segment by default.
- R9: Relative mode (`mode` = 3'b111) adds the sign-extended `disp[7:0]` to `regIp`, with the code segment by default.
- R10: When `ovrValid` is 1, `ovrSeg` replaces the default segment in every mode except string destination.
- R11: Segment codes, used on both `ovrSeg` and `outSeg`: 2'b00 extra, 2'b01 stack, 2'b10 code, 2'b11 data.
- R12: `outValid` is high for exactly the cycle after each edge that captured a request. The data outputs keep their values when no request is captured. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| indSel | input | 2 | Register chosen for register-indirect mode |
| baseSel | input | 1 | Base register chosen: 0 general, 1 stack-frame |
| idxSel | input | 1 | Index register chosen: 0 source, 1 destination |
| dispWide | input | 1 | 1: 16-bit unsigned displacement, 0: sign-extended 8-bit |
| disp | input | 16 | Displacement or direct address |
| ovrValid | input | 1 | Segment override present |
| ovrSeg | input | 2 | Override segment code |
| segCode | input | 16 | Code segment register |
| segData | input | 16 | Data segment register |
| segExtra | input | 16 | Extra segment register |
| segStack | input | 16 | Stack segment register |
| regBase | input | 16 | General base register |
| regFrame | input | 16 | Stack-frame base pointer |
| regSrc | input | 16 | Source index register |
| regDst | input | 16 | Destination index register |
| regIp | input | 16 | Instruction pointer |
| outValid | output | 1 | Result valid |
| outEa | output | 16 | Effective address |
| outPhys | output | 20 | Physical address |
| outSeg | output | 2 | Code of the segment in use |

## Verification
The assertions check on every cycle that the valid strobe follows a captured request by exactly one edge, that the data outputs hold when nothing is captured, and that the low nibble of the physical address matches the effective address. They also check that string destinations always land in the extra segment, that an accepted override appears on the segment output, that relative requests produce the instruction pointer plus the signed short displacement in the code segment, and that a stack-frame indirect reference selects the stack segment. The full sums of base, index and displacement only show up in the bench's scenarios, as do sign extension against unsigned addition, wraparound at 2^16 and 2^20, and the default-segment choice in every mode. The bench compares these against its own model, using random register values and directed corner values.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [2:0] {
    MODE_DIRECT  = 3'd0,
    MODE_REGIND  = 3'd1,
    MODE_BASED   = 3'd2,
    MODE_INDEXED = 3'd3,
    MODE_BASEIDX = 3'd4,
    MODE_STRSRC  = 3'd5,
    MODE_STRDST  = 3'd6,
    MODE_REL     = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_STACK = 2'b01,
    SEG_CODE  = 2'b10,
    SEG_DATA  = 2'b11
  } seg_e;

  // first effective-address term
  typedef enum logic [2:0] {
    TA_ZERO  = 3'd0,
    TA_BASE  = 3'd1,
    TA_FRAME = 3'd2,
    TA_SRC   = 3'd3,
    TA_DST   = 3'd4,
    TA_IP    = 3'd5
  } terma_e;

  // second effective-address term (index in based-indexed mode)
  typedef enum logic [1:0] {
    TB_ZERO = 2'd0,
    TB_SRC  = 2'd1,
    TB_DST  = 2'd2
  } termb_e;

  // how the displacement enters the sum
  typedef enum logic [1:0] {
    DK_NONE = 2'd0,
    DK_SEXT = 2'd1,
    DK_WIDE = 2'd2
  } disp_e;

  typedef struct packed {
    logic   load;
    terma_e termA;
    termb_e termB;
    disp_e  dispKind;
    seg_e   seg;
  } strobe_t;

endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] mode,
  input  logic [1:0] indSel,
  input  logic       baseSel,
  input  logic       idxSel,
  input  logic       dispWide,
  input  logic       ovrValid,
  input  logic [1:0] ovrSeg,
  output strobe_t    strobes
);

  mode_e  modeK;
  seg_e   defSeg;
  terma_e termA;
  termb_e termB;
  disp_e  dispKind;
  disp_e  offsetKind;
  logic   ovrAllowed;

  assign modeK      = mode_e'(mode);
  assign offsetKind = dispWide ? DK_WIDE : DK_SEXT;

  always_comb begin
    defSeg     = SEG_DATA;
    termA      = TA_ZERO;
    termB      = TB_ZERO;
    dispKind   = DK_NONE;
    ovrAllowed = 1'b1;
    case (modeK)
      MODE_DIRECT: begin
        dispKind = DK_WIDE;
      end
      MODE_REGIND: begin
        case (indSel)
          2'b00: termA = TA_BASE;
          2'b01: begin
            termA  = TA_FRAME;
            defSeg = SEG_STACK;
          end
          2'b10: termA = TA_SRC;
          default: termA = TA_DST;
        endcase
      end
      MODE_BASED: begin
        termA    = baseSel ? TA_FRAME : TA_BASE;
        defSeg   = baseSel ? SEG_STACK : SEG_DATA;
        dispKind = offsetKind;
      end
      MODE_INDEXED: begin
        termA    = idxSel ? TA_DST : TA_SRC;
        dispKind = offsetKind;
      end
      MODE_BASEIDX: begin
        termA    = baseSel ? TA_FRAME : TA_BASE;
        termB    = idxSel ? TB_DST : TB_SRC;
        defSeg   = baseSel ? SEG_STACK : SEG_DATA;
        dispKind = offsetKind;
      end
      MODE_STRSRC: begin
        termA = TA_SRC;
      end
      MODE_STRDST: begin
        termA      = TA_DST;
        defSeg     = SEG_EXTRA;
        ovrAllowed = 1'b0;
      end
      MODE_REL: begin
        termA    = TA_IP;
        dispKind = DK_SEXT;
        defSeg   = SEG_CODE;
      end
      default: ;
    endcase
  end

  always_comb begin
    strobes.load     = reqValid;
    strobes.termA    = termA;
    strobes.termB    = termB;
    strobes.dispKind = dispKind;
    strobes.seg      = (ovrValid && ovrAllowed) ? seg_e'(ovrSeg) : defSeg;
  end

endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SHORT_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  strobe_t                       strobes,
  input  logic [WORD_W-1:0]             disp,
  input  logic [WORD_W-1:0]             segCode,
  input  logic [WORD_W-1:0]             segData,
  input  logic [WORD_W-1:0]             segExtra,
  input  logic [WORD_W-1:0]             segStack,
  input  logic [WORD_W-1:0]             regBase,
  input  logic [WORD_W-1:0]             regFrame,
  input  logic [WORD_W-1:0]             regSrc,
  input  logic [WORD_W-1:0]             regDst,
  input  logic [WORD_W-1:0]             regIp,
  output logic                          validQ,
  output logic [WORD_W-1:0]             eaQ,
  output logic [WORD_W+SEG_SHIFT-1:0]   physQ,
  output logic [1:0]                    segQ
);

  localparam int PHYS_W = WORD_W + SEG_SHIFT;
  localparam int EXT_W  = WORD_W - SHORT_W;

  logic [WORD_W-1:0] termAVal;
  logic [WORD_W-1:0] termBVal;
  logic [WORD_W-1:0] dispVal;
  logic [WORD_W-1:0] shortExt;
  logic [WORD_W-1:0] eaNext;
  logic [WORD_W-1:0] segVal;
  logic [PHYS_W-1:0] physNext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign shortExt = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    end else begin : g_noext
      assign shortExt = disp;
    end
  endgenerate

  always_comb begin
    case (strobes.termA)
      TA_BASE:  termAVal = regBase;
      TA_FRAME: termAVal = regFrame;
      TA_SRC:   termAVal = regSrc;
      TA_DST:   termAVal = regDst;
      TA_IP:    termAVal = regIp;
      default:  termAVal = '0;
    endcase
  end

  always_comb begin
    case (strobes.termB)
      TB_SRC:  termBVal = regSrc;
      TB_DST:  termBVal = regDst;
      default: termBVal = '0;
    endcase
  end

  always_comb begin
    case (strobes.dispKind)
      DK_SEXT: dispVal = shortExt;
      DK_WIDE: dispVal = disp;
      default: dispVal = '0;
    endcase
  end

  // sum wraps at the word width by truncation
  assign eaNext = termAVal + termBVal + dispVal;

  always_comb begin
    case (strobes.seg)
      SEG_EXTRA: segVal = segExtra;
      SEG_STACK: segVal = segStack;
      SEG_CODE:  segVal = segCode;
      default:   segVal = segData;
    endcase
  end

  assign physNext = {segVal, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, eaNext};

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
      eaQ    <= '0;
      physQ  <= '0;
      segQ   <= '0;
    end else begin
      validQ <= strobes.load;
      if (strobes.load) begin
        eaQ   <= eaNext;
        physQ <= physNext;
        segQ  <= strobes.seg;
      end
    end
  end

  // R1
  phys_low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    physQ[SEG_SHIFT-1:0] == eaQ[SEG_SHIFT-1:0]);

  // R12
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> validQ);

  // R12
  valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> !validQ);

  // R12
  hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> ($stable(eaQ) && $stable(physQ) && $stable(segQ)));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SHORT_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reqValid,
  input  logic [2:0]                  mode,
  input  logic [1:0]                  indSel,
  input  logic                        baseSel,
  input  logic                        idxSel,
  input  logic                        dispWide,
  input  logic [WORD_W-1:0]           disp,
  input  logic                        ovrValid,
  input  logic [1:0]                  ovrSeg,
  input  logic [WORD_W-1:0]           segCode,
  input  logic [WORD_W-1:0]           segData,
  input  logic [WORD_W-1:0]           segExtra,
  input  logic [WORD_W-1:0]           segStack,
  input  logic [WORD_W-1:0]           regBase,
  input  logic [WORD_W-1:0]           regFrame,
  input  logic [WORD_W-1:0]           regSrc,
  input  logic [WORD_W-1:0]           regDst,
  input  logic [WORD_W-1:0]           regIp,
  output logic                        outValid,
  output logic [WORD_W-1:0]           outEa,
  output logic [WORD_W+SEG_SHIFT-1:0] outPhys,
  output logic [1:0]                  outSeg
);

  localparam int EXT_W = WORD_W - SHORT_W;

  strobe_t strobes;

  seg_addr_ctrl u_ctrl (
    .reqValid (reqValid),
    .mode     (mode),
    .indSel   (indSel),
    .baseSel  (baseSel),
    .idxSel   (idxSel),
    .dispWide (dispWide),
    .ovrValid (ovrValid),
    .ovrSeg   (ovrSeg),
    .strobes  (strobes)
  );

  seg_addr_dp #(
    .WORD_W    (WORD_W),
    .SEG_SHIFT (SEG_SHIFT),
    .SHORT_W   (SHORT_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .disp     (disp),
    .segCode  (segCode),
    .segData  (segData),
    .segExtra (segExtra),
    .segStack (segStack),
    .regBase  (regBase),
    .regFrame (regFrame),
    .regSrc   (regSrc),
    .regDst   (regDst),
    .regIp    (regIp),
    .validQ   (outValid),
    .eaQ      (outEa),
    .physQ    (outPhys),
    .segQ     (outSeg)
  );

  // R7
  strdst_extra_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && mode == MODE_STRDST) |=> (outSeg == SEG_EXTRA && outEa == $past(regDst)));

  // R10
  override_used_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && ovrValid && mode != MODE_STRDST) |=> (outSeg == $past(ovrSeg)));

  // R9
  relative_ea_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && mode == MODE_REL) |=>
      (outEa == $past(regIp + {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]})));

  // R9
  relative_code_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !ovrValid && mode == MODE_REL) |=> (outSeg == SEG_CODE));

  // R2
  frame_stack_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !ovrValid && mode == MODE_REGIND && indSel == 2'b01) |=>
      (outSeg == SEG_STACK && outEa == $past(regFrame)));

endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  indSel = '0;
  logic        baseSel = 1'b0;
  logic        idxSel = 1'b0;
  logic        dispWide = 1'b0;
  logic [15:0] disp = '0;
  logic        ovrValid = 1'b0;
  logic [1:0]  ovrSeg = '0;
  logic [15:0] segCode = '0, segData = '0, segExtra = '0, segStack = '0;
  logic [15:0] regBase = '0, regFrame = '0, regSrc = '0, regDst = '0, regIp = '0;
  logic        outValid;
  logic [15:0] outEa;
  logic [19:0] outPhys;
  logic [1:0]  outSeg;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_addr_gen uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .mode(mode), .indSel(indSel),
    .baseSel(baseSel), .idxSel(idxSel), .dispWide(dispWide), .disp(disp),
    .ovrValid(ovrValid), .ovrSeg(ovrSeg), .segCode(segCode), .segData(segData),
    .segExtra(segExtra), .segStack(segStack), .regBase(regBase), .regFrame(regFrame),
    .regSrc(regSrc), .regDst(regDst), .regIp(regIp), .outValid(outValid),
    .outEa(outEa), .outPhys(outPhys), .outSeg(outSeg)
  );

  typedef struct packed {
    logic [15:0] ea;
    logic [19:0] phys;
    logic [1:0]  seg;
  } expect_t;

  function automatic string modeReq(input logic [2:0] m);
    case (m)
      3'd0: return "R8";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  // model built from the requirements
  function automatic expect_t refModel();
    expect_t r;
    logic [15:0] off;
    logic [15:0] shortOff;
    logic [15:0] baseV;
    logic [15:0] idxV;
    logic [1:0]  s;
    int unsigned segV;
    shortOff = {{8{disp[7]}}, disp[7:0]};
    off   = dispWide ? disp : shortOff;
    baseV = baseSel ? regFrame : regBase;
    idxV  = idxSel ? regDst : regSrc;
    s = 2'b11;
    case (mode)
      3'd0: r.ea = disp;
      3'd1: begin
        r.ea = (indSel == 2'd0) ? regBase : (indSel == 2'd1) ? regFrame :
               (indSel == 2'd2) ? regSrc : regDst;
        if (indSel == 2'd1) s = 2'b01;
      end
      3'd2: begin r.ea = baseV + off; if (baseSel) s = 2'b01; end
      3'd3: r.ea = idxV + off;
      3'd4: begin r.ea = baseV + idxV + off; if (baseSel) s = 2'b01; end
      3'd5: r.ea = regSrc;
      3'd6: begin r.ea = regDst; s = 2'b00; end
      default: begin r.ea = regIp + shortOff; s = 2'b10; end
    endcase
    if (ovrValid && mode != 3'd6) s = ovrSeg;
    r.seg = s;
    case (s)
      2'b00: segV = segExtra;
      2'b01: segV = segStack;
      2'b10: segV = segCode;
      default: segV = segData;
    endcase
    r.phys = 20'((segV * 16 + r.ea) % 32'h100000);
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // present the current inputs as one request and check one cycle later
  task automatic issue(input string eaReq);
    expect_t e;
    e = refModel();
    @(negedge clk);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R12", "outValid", 32'(outValid), 32'd1);
    check(eaReq, "outEa", 32'(outEa), 32'(e.ea));
    check("R1", "outPhys", 32'(outPhys), 32'(e.phys));
    check((ovrValid && mode != 3'd6) ? "R10" : "R11", "outSeg", 32'(outSeg), 32'(e.seg));
  endtask

  task automatic randomize_regs();
    segCode = 16'($urandom); segData = 16'($urandom);
    segExtra = 16'($urandom); segStack = 16'($urandom);
    regBase = 16'($urandom); regFrame = 16'($urandom);
    regSrc = 16'($urandom); regDst = 16'($urandom); regIp = 16'($urandom);
    disp = 16'($urandom);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] keepEa;
    logic [19:0] keepPhys;
    logic [1:0]  keepSeg;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check("R12", "reset outValid", 32'(outValid), 32'd0);
    check("R12", "reset outEa", 32'(outEa), 32'd0);
    check("R12", "reset outPhys", 32'(outPhys), 32'd0);
    check("R12", "reset outSeg", 32'(outSeg), 32'd0);

    // R1 physical wrap: data FFFF, direct FFFF -> 0FFEF
    mode = 3'd0; segData = 16'hFFFF; disp = 16'hFFFF; ovrValid = 1'b0;
    issue("R8");
    check("R1", "phys wrap", 32'(outPhys), 32'h0FFEF);

    // R4 effective address wrap with unsigned wide displacement
    mode = 3'd2; baseSel = 1'b0; regBase = 16'hFFF0; dispWide = 1'b1; disp = 16'h0020;
    issue("R4");
    check("R4", "ea wrap", 32'(outEa), 32'h0010);

    // R4 short displacement: negative, upper byte ignored
    regBase = 16'h0100; dispWide = 1'b0; disp = 16'hAB80;
    issue("R4");
    check("R4", "sign extend", 32'(outEa), 32'h0080);

    // R3 stack-frame base selects stack
    baseSel = 1'b1; regFrame = 16'h1234; segStack = 16'h2000; disp = 16'h0004;
    issue("R3");
    check("R3", "frame seg", 32'(outSeg), 32'd1);
    check("R3", "frame phys", 32'(outPhys), 32'h21238);

    // R7 string destination ignores override
    mode = 3'd6; regDst = 16'h0042; segExtra = 16'h3000; ovrValid = 1'b1; ovrSeg = 2'b10;
    issue("R7");
    check("R7", "strdst seg", 32'(outSeg), 32'd0);

    // R10 override on string source
    mode = 3'd5; regSrc = 16'h0010; segCode = 16'h4000;
    issue("R10");
    check("R10", "override seg", 32'(outSeg), 32'd2);
    ovrValid = 1'b0;

    // R9 relative with negative short displacement
    mode = 3'd7; regIp = 16'h0005; disp = 16'h00FE; segCode = 16'h1000;
    issue("R9");
    check("R9", "relative ea", 32'(outEa), 32'h0003);
    check("R9", "relative phys", 32'(outPhys), 32'h10003);

    // R12 outputs hold while no request, with inputs changing
    keepEa = outEa; keepPhys = outPhys; keepSeg = outSeg;
    regIp = 16'h7777; mode = 3'd3; segCode = 16'hBEEF;
    repeat (3) @(negedge clk);
    check("R12", "hold valid", 32'(outValid), 32'd0);
    check("R12", "hold ea", 32'(outEa), 32'(keepEa));
    check("R12", "hold phys", 32'(outPhys), 32'(keepPhys));
    check("R12", "hold seg", 32'(outSeg), 32'(keepSeg));

    // random mix over every mode
    for (int i = 0; i < 3000; i++) begin
      randomize_regs();
      mode     = 3'($urandom);
      indSel   = 2'($urandom);
      baseSel  = 1'($urandom);
      idxSel   = 1'($urandom);
      dispWide = 1'($urandom);
      ovrValid = (($urandom % 4) == 0);
      ovrSeg   = 2'($urandom);
      issue(modeReq(mode));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule